// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the header part of a LIN master frame on a single serial line. A one-cycle start request makes it capture its configuration and send a long low break, then a high delimiter. Depending on the header-select code, it may also send the synchronisation character and the protected identifier character. Each bit lasts from one pulse of an external bit-time tick to the next. The surrounding logic provides that tick, which is one clock wide and arrives once per bit time. The block holds its line high when idle.

The identifier byte is either used exactly as supplied, or the block generates its two parity bits from the six identifier bits. While a header is being sent, the block compares the looped-back receive line with its own output at the last clock of every bit time. A mismatch sets a sticky error flag, which a clear strobe resets.

Top module: `lin_hdr_tx`

## Requirements
- R1: In the clock cycle after an accepted request, `tx_out` goes low. It stays low for `brk_len`+1 bit times, and each bit time ends on a cycle with `bit_tick` high.
- R2: After the break, `tx_out` is high for a delimiter of 1, 2, 3 or 4 bit times when `dlm_len` is 0, 1, 2 or 3.
- R3: `hdr_sel` = 0 sends only break and delimiter. A value of 1 adds the sync character. A value of 2 adds the sync character and then the identifier character. A value of 3 behaves like 0.
- R4: Each character is ten bit times long: a start bit of 0, eight data bits with bit 0 first, and a stop bit of 1. The sync character carries 0x55.
- R5: With `par_gen_en`=1, the identifier data is `pid_in[5:0]` in bits 5..0. Bit 6 is id0^id1^id2^id4 and bit 7 is the inverse of id1^id3^id4^id5. With `par_gen_en`=0, the block sends `pid_in` unchanged.
- R6: `busy` rises in the cycle after an accepted request. It falls in the cycle after the tick that ends the last bit of the selected header. `tx_out` changes only after a tick while busy, and it is high whenever `busy` is low.
- R7: A request while `busy` is high is ignored. Length codes, select code and identifier are captured when a request is accepted, so later changes do not affect the header in progress.
- R8: With `berr_en`=1, if `rx_in` differs from `tx_out` in a tick cycle while busy, `berr_flag` is set in the next cycle. A mismatch in a non-tick cycle, or one with `berr_en`=0, does not set it. The flag stays set until a `berr_clr` cycle clears it, and a set in the same cycle wins.
- R9: After reset, `tx_out`=1, `busy`=0 and `berr_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Start-header strobe, taken when not busy |
| brk_len | input | 4 | Break length code (bit times minus one) |
| dlm_len | input | 2 | Delimiter length code (bit times minus one) |
| hdr_sel | input | 2 | Fields to send: 0 break, 1 +sync, 2 +sync+ID, 3 as 0 |
| pid_in | input | 8 | Identifier (low six bits) or full protected byte |
| par_gen_en | input | 1 | Generate the two identifier parity bits |
| berr_en | input | 1 | Enable bit-error monitoring |
| berr_clr | input | 1 | Clear the bit-error flag |
| bit_tick | input | 1 | One-cycle pulse ending each bit time |
| rx_in | input | 1 | Looped-back bus level |
| tx_out | output | 1 | Serial output line |
| busy | output | 1 | Header in progress; clears itself at the end |
| berr_flag | output | 1 | Sticky bit-error flag |

## Verification
The hardest case to reach is a bus disagreement that occurs only inside a bit time and not in the tick cycle that ends it. This mismatch must leave the error flag clear. The same stimulus must also show that a disagreement in the tick cycle does set the flag. The bench routes `rx_in` through an XOR with an injection signal. For each header it drives the disagreement either in the tick cycle of a randomly chosen bit or in an idle cycle between ticks. The bench also pulses a second request with different settings in the middle of a header and then checks that the bit stream still matches the settings captured at the start.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_DELIM,
    ST_SYNC,
    ST_IDENT
  } seq_state_t;

  localparam logic [7:0] SYNC_BYTE  = 8'h55;
  localparam int         CHAR_BITS  = 10;
  localparam logic [1:0] SEL_BREAK  = 2'd0;
  localparam logic [1:0] SEL_SYNC   = 2'd1;
  localparam logic [1:0] SEL_FULL   = 2'd2;

  function automatic logic [7:0] protect_id(input logic [5:0] id);
    logic p_lo;
    logic p_hi;
    p_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
    p_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p_hi, p_lo, id};
  endfunction

endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] raw_byte,
  input  logic              gen_en,
  output logic [BYTE_W-1:0] id_byte
);
  import lin_hdr_pkg::*;

  localparam int ID_W = 6;

  generate
    if (BYTE_W == 8) begin : g_std
      always_comb begin
        if (gen_en) id_byte = protect_id(raw_byte[ID_W-1:0]);
        else        id_byte = raw_byte;
      end
    end else begin : g_raw
      always_comb id_byte = raw_byte;
    end
  endgenerate

endmodule

// File: rtl/lin_bit_mon.sv
module lin_bit_mon (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic tx_lvl,
  input  logic rx_lvl,
  input  logic clr,
  output logic err_flag
);
  logic flag_q;
  logic mismatch;

  always_comb mismatch = sample_en && (tx_lvl != rx_lvl);

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (mismatch) flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign err_flag = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr) |=> err_flag); // R8

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr && !sample_en) |=> !err_flag); // R8

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq #(
  parameter int BRK_W  = 4,
  parameter int DLM_W  = 2,
  parameter int SEL_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BRK_W-1:0]  brk_len,
  input  logic [DLM_W-1:0]  dlm_len,
  input  logic [SEL_W-1:0]  hdr_sel,
  input  logic [BYTE_W-1:0] id_byte,
  input  logic              bit_tick,
  output logic              tx,
  output logic              busy
);
  import lin_hdr_pkg::*;

  localparam int FRAME_W = BYTE_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = (BRK_W > IDX_W) ? ((BRK_W > DLM_W) ? BRK_W : DLM_W)
                                           : ((IDX_W > DLM_W) ? IDX_W : DLM_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  seq_state_t         st_q,  st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shf_q, shf_d;
  logic [BRK_W-1:0]   brk_q, brk_d;
  logic [DLM_W-1:0]   dlm_q, dlm_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [BYTE_W-1:0]  id_q,  id_d;
  logic               tx_q,  tx_d;
  logic               want_sync;
  logic               want_id;

  always_comb begin
    want_sync = (sel_q == SEL_W'(SEL_SYNC)) || (sel_q == SEL_W'(SEL_FULL));
    want_id   = (sel_q == SEL_W'(SEL_FULL));
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    shf_d = shf_q;
    brk_d = brk_q;
    dlm_d = dlm_q;
    sel_d = sel_q;
    id_d  = id_q;
    tx_d  = tx_q;
    case (st_q)
      ST_IDLE: begin
        tx_d = 1'b1;
        if (start) begin
          st_d  = ST_BREAK;
          cnt_d = '0;
          tx_d  = 1'b0;
          brk_d = brk_len;
          dlm_d = dlm_len;
          sel_d = hdr_sel;
          id_d  = id_byte;
        end
      end
      ST_BREAK: begin
        if (bit_tick) begin
          if (cnt_q == CNT_W'(brk_q)) begin
            st_d  = ST_DELIM;
            cnt_d = '0;
            tx_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DELIM: begin
        if (bit_tick) begin
          if (cnt_q == CNT_W'(dlm_q)) begin
            cnt_d = '0;
            if (want_sync) begin
              st_d  = ST_SYNC;
              shf_d = {1'b1, BYTE_W'(SYNC_BYTE), 1'b0};
              tx_d  = 1'b0;
            end else begin
              st_d = ST_IDLE;
              tx_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SYNC, ST_IDENT: begin
        if (bit_tick) begin
          if (cnt_q == LAST_IDX) begin
            cnt_d = '0;
            if (st_q == ST_SYNC && want_id) begin
              st_d  = ST_IDENT;
              shf_d = {1'b1, id_q, 1'b0};
              tx_d  = 1'b0;
            end else begin
              st_d = ST_IDLE;
              tx_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
            shf_d = shf_q >> 1;
            tx_d  = shf_q[1];
          end
        end
      end
      default: begin
        st_d = ST_IDLE;
        tx_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      shf_q <= '1;
      brk_q <= '0;
      dlm_q <= '0;
      sel_q <= '0;
      id_q  <= '0;
      tx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      shf_q <= shf_d;
      brk_q <= brk_d;
      dlm_q <= dlm_d;
      sel_q <= sel_d;
      id_q  <= id_d;
      tx_q  <= tx_d;
    end
  end

  assign tx   = tx_q;
  assign busy = (st_q != ST_IDLE);

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BREAK) |-> !tx_q); // R1

  AST_DELIM_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DELIM) |-> tx_q); // R2

  AST_CHAR_START: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SYNC || st_q == ST_IDENT) && cnt_q == '0) |-> !tx_q); // R4

  AST_CHAR_STOP: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_SYNC || st_q == ST_IDENT) && cnt_q == LAST_IDX) |-> tx_q); // R4

  AST_IDENT_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDENT) |-> want_id); // R3

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
  parameter int BRK_W  = 4,
  parameter int DLM_W  = 2,
  parameter int SEL_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic [BRK_W-1:0]  brk_len,
  input  logic [DLM_W-1:0]  dlm_len,
  input  logic [SEL_W-1:0]  hdr_sel,
  input  logic [BYTE_W-1:0] pid_in,
  input  logic              par_gen_en,
  input  logic              berr_en,
  input  logic              berr_clr,
  input  logic              bit_tick,
  input  logic              rx_in,
  output logic              tx_out,
  output logic              busy,
  output logic              berr_flag
);

  logic [BYTE_W-1:0] id_byte;
  logic              start;
  logic              seq_busy;
  logic              seq_tx;
  logic              chk_en;

  always_comb begin
    start  = send_req && !seq_busy;
    chk_en = seq_busy && berr_en && bit_tick;
  end

  lin_pid_gen #(.BYTE_W(BYTE_W)) pid_i (
    .raw_byte (pid_in),
    .gen_en   (par_gen_en),
    .id_byte  (id_byte)
  );

  lin_hdr_seq #(
    .BRK_W (BRK_W),
    .DLM_W (DLM_W),
    .SEL_W (SEL_W),
    .BYTE_W(BYTE_W)
  ) seq_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .brk_len (brk_len),
    .dlm_len (dlm_len),
    .hdr_sel (hdr_sel),
    .id_byte (id_byte),
    .bit_tick(bit_tick),
    .tx      (seq_tx),
    .busy    (seq_busy)
  );

  lin_bit_mon mon_i (
    .clk      (clk),
    .rst      (rst),
    .sample_en(chk_en),
    .tx_lvl   (seq_tx),
    .rx_lvl   (rx_in),
    .clr      (berr_clr),
    .err_flag (berr_flag)
  );

  assign tx_out = seq_tx;
  assign busy   = seq_busy;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_out); // R6

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && send_req) |=> (busy && !tx_out)); // R1

  AST_TX_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> ($stable(tx_out) && busy)); // R6

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !berr_flag) |=> !berr_flag); // R8

endmodule

// File: tb/lin_hdr_tx_tb_top.sv
module lin_hdr_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       send_req, par_gen_en, berr_en, berr_clr, bit_tick, inj;
  logic [3:0] brk_len;
  logic [1:0] dlm_len, hdr_sel;
  logic [7:0] pid_in;
  logic       tx_out, busy, berr_flag, rx_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit exp_bits [0:63];
  int exp_len;

  always #10 clk = ~clk;

  assign rx_in = tx_out ^ inj;

  lin_hdr_tx dut_i (
    .clk(clk), .rst(rst), .send_req(send_req), .brk_len(brk_len),
    .dlm_len(dlm_len), .hdr_sel(hdr_sel), .pid_in(pid_in),
    .par_gen_en(par_gen_en), .berr_en(berr_en), .berr_clr(berr_clr),
    .bit_tick(bit_tick), .rx_in(rx_in), .tx_out(tx_out), .busy(busy),
    .berr_flag(berr_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_id(input logic [7:0] raw, input bit gen);
    logic [7:0] b;
    b = raw;
    if (gen) begin
      b[6] = raw[0] ^ raw[1] ^ raw[2] ^ raw[4];
      b[7] = ~(raw[1] ^ raw[3] ^ raw[4] ^ raw[5]);
    end
    return b;
  endfunction

  function automatic void push_char(input logic [7:0] d);
    exp_bits[exp_len] = 1'b0; exp_len++;
    for (int i = 0; i < 8; i++) begin exp_bits[exp_len] = d[i]; exp_len++; end
    exp_bits[exp_len] = 1'b1; exp_len++;
  endfunction

  function automatic void build(input int brk, input int dlm, input int sel,
                                input logic [7:0] raw, input bit gen);
    exp_len = 0;
    for (int i = 0; i <= brk; i++) begin exp_bits[exp_len] = 1'b0; exp_len++; end
    for (int i = 0; i <= dlm; i++) begin exp_bits[exp_len] = 1'b1; exp_len++; end
    if (sel == 1 || sel == 2) push_char(8'h55);
    if (sel == 2) push_char(ref_id(raw, gen));
  endfunction

  function automatic string region(input int k, input int brk, input int dlm);
    if (k <= brk) return "R1 break";
    if (k <= brk + dlm + 1) return "R2 delimiter";
    if (k < brk + dlm + 12) return "R4 sync char";
    return "R5 id char";
  endfunction

  // inj_mode: 0 none, 1 in tick cycle of bit inj_k, 2 in a non-tick cycle
  task automatic run_hdr(input int brk, input int dlm, input int sel,
                         input logic [7:0] raw, input bit gen, input bit en,
                         input int inj_mode, input bit disturb);
    int eff_sel;
    int inj_k;
    eff_sel = (sel == 3) ? 0 : sel;
    build(brk, dlm, eff_sel, raw, gen);
    inj_k = $urandom_range(exp_len - 1, 0);
    @(negedge clk);
    brk_len = brk[3:0]; dlm_len = dlm[1:0]; hdr_sel = sel[1:0];
    pid_in = raw; par_gen_en = gen; berr_en = en; send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
    check(busy == 1'b1 && tx_out == 1'b0, "R6 busy/low after request", busy, 1);
    for (int k = 0; k < exp_len; k++) begin
      int gap;
      gap = $urandom_range(3, 1);
      for (int g = 0; g < gap; g++) begin
        if (disturb && k == 1 && g == 0) begin
          // R7: second request with other settings is ignored
          send_req = 1'b1; brk_len = ~brk_len; hdr_sel = 2'd2;
          pid_in = ~pid_in; par_gen_en = ~par_gen_en; dlm_len = ~dlm_len;
        end
        if (inj_mode == 2 && k == inj_k && g == 0) inj = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        inj = 1'b0;
      end
      bit_tick = 1'b1;
      if (inj_mode == 1 && k == inj_k) inj = 1'b1;
      #1;
      check(tx_out == exp_bits[k] && busy, region(k, brk, dlm), tx_out, exp_bits[k]);
      @(negedge clk);
      bit_tick = 1'b0;
      inj = 1'b0;
    end
    check(busy == 1'b0 && tx_out == 1'b1, "R3 header ends at selected length", busy, 0);
    check(berr_flag == (en && inj_mode == 1), "R8 bit error flag",
          berr_flag, (en && inj_mode == 1));
    berr_clr = 1'b1;
    @(negedge clk);
    berr_clr = 1'b0;
    check(berr_flag == 1'b0, "R8 flag cleared", berr_flag, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst = 1'b1; send_req = 0; par_gen_en = 0; berr_en = 0; berr_clr = 0;
    bit_tick = 0; inj = 0; brk_len = 0; dlm_len = 0; hdr_sel = 0; pid_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(tx_out == 1'b1 && busy == 1'b0 && berr_flag == 1'b0, "R9 reset state",
          {tx_out, busy, berr_flag}, 4);

    // directed corners
    run_hdr(0, 0, 0, 8'h00, 0, 1, 0, 0);     // R1 R2 shortest
    run_hdr(15, 3, 2, 8'h3C, 1, 1, 0, 0);    // R1 R2 R5 longest
    run_hdr(4, 1, 3, 8'hFF, 0, 0, 0, 0);     // R3 code 3 acts as break only
    run_hdr(2, 2, 1, 8'h12, 0, 1, 0, 0);     // R3 R4 sync only
    run_hdr(5, 0, 2, 8'hA5, 0, 1, 0, 0);     // R5 raw byte
    run_hdr(5, 0, 2, 8'h00, 1, 1, 0, 0);     // R5 parity of zero id
    run_hdr(3, 1, 2, 8'h15, 1, 1, 0, 1);     // R7 request while busy
    run_hdr(3, 1, 2, 8'h2A, 1, 1, 1, 0);     // R8 error at tick
    run_hdr(3, 1, 2, 8'h2A, 1, 1, 2, 0);     // R8 error between ticks
    run_hdr(3, 1, 2, 8'h2A, 1, 0, 1, 0);     // R8 monitoring off

    for (int n = 0; n < 40; n++) begin
      run_hdr($urandom_range(15, 0), $urandom_range(3, 0), $urandom_range(3, 0),
              8'($urandom), 1'($urandom), 1'($urandom), $urandom_range(2, 0),
              1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule